// File: doc/BRIEF.md
# Clock Synthesizer Reconfiguration Sequencer

This block reprograms an on-chip clock synthesizer through its dynamic reconfiguration port. A one-cycle start request captures eleven 16-bit configuration words. The block then holds the synthesizer in reset and writes each word to its own port register, one transaction at a time, waiting for the port's ready acknowledge after each write. After the last acknowledge it releases reset, waits a settling window of 100 microseconds, and samples the lock indicator once. It ends with a one-cycle done pulse and a two-bit status code.

While no sequence is running, a host can perform a single read or write transaction on the port through a request/acknowledge path, and can drive the synthesizer reset directly. Every wait for ready is bounded by a timeout. When a timeout expires during a sequence, the run is aborted with its own status code.

Top module: `clk_reprog_seq`

## Requirements
- R1: On a sequence, configuration word i (taken from `cfg_words[16*i +: 16]`) is written to the i-th address of the list 0x08, 0x09, 0x14, 0x15, 0x16, 0x18, 0x19, 0x1A, 0x28, 0x4E, 0x4F. Exactly eleven writes are made, in that order.
- R2: `syn_rst` is high from the cycle after the start is taken, through every configuration write, until the eleventh write is acknowledged. It goes low in the cycle after that acknowledge.
- R3: Each transaction raises `drp_en` for exactly one cycle. `drp_we` is high with it for writes and low for reads. No new strobe is issued until the previous one has been acknowledged or has timed out.
- R4: After reset release the block stays busy for exactly CLK_HZ/10000 cycles, then samples `syn_locked`: status 00 if it is high, 01 if it is low.
- R5: If `drp_rdy` is absent for RDY_TIMEOUT cycles after a sequence strobe, the run aborts. Status becomes 10, done pulses, and the sequence's hold on reset is dropped.
- R6: The configuration words are registered when the start is taken. Changing `cfg_words` during a run has no effect on the written data.
- R7: A `start` or `host_req` that arrives while `busy` is high is ignored.
- R8: `done` is a one-cycle pulse. `status` is cleared to 00 when a start is taken and otherwise changes only together with `done`.
- R9: A host request performs one transaction with `host_we`, `host_addr` and `host_wdata`. Completion gives a one-cycle `host_ack`. For reads, `host_rdata` holds the data returned with ready.
- R10: When no sequence is running, `syn_rst` follows `host_rst`. During a sequence `host_rst` has no effect.
- R11: After reset, `busy`, `done`, `host_ack`, `drp_en` and `status` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, also the port clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start a reconfiguration sequence |
| cfg_words | input | 176 | Eleven configuration words, word i at bits 16*i+15:16*i |
| host_req | input | 1 | Single host transaction request |
| host_we | input | 1 | Host transaction is a write |
| host_addr | input | 7 | Host transaction address |
| host_wdata | input | 16 | Host write data |
| host_ack | output | 1 | Host transaction complete pulse |
| host_rdata | output | 16 | Host read data |
| host_rst | input | 1 | Direct synthesizer reset when idle |
| drp_en | output | 1 | Port enable strobe |
| drp_we | output | 1 | Port write enable |
| drp_addr | output | 7 | Port address |
| drp_di | output | 16 | Port write data |
| drp_do | input | 16 | Port read data |
| drp_rdy | input | 1 | Port ready acknowledge |
| syn_rst | output | 1 | Synthesizer reset |
| syn_locked | input | 1 | Synthesizer lock indicator |
| busy | output | 1 | Sequence or host transaction active |
| done | output | 1 | Sequence finished pulse |
| status | output | 2 | 00 ok, 01 no lock, 10 ready timeout |

## Verification
The in-line assertions check the following on every cycle: the strobe is one cycle wide, a new transaction starts only on an idle port engine, reset is high during every sequence strobe, done is a pulse, status changes only with done or a new start, and a timeout leads to status 10. The exact address order, the word values, the length of the settling window, that late input changes have no effect, and that a start or request during busy is ignored all need the bench's scenarios. There a port responder with varying latency and a stalled mode is checked against a behavioural model of the expected writes.

// File: rtl/clkcfg_pkg.sv
package clkcfg_pkg;
  localparam int DRP_AW    = 7;
  localparam int DRP_DW    = 16;
  localparam int NUM_WORDS = 11;

  typedef enum logic [1:0] {
    ST_OK      = 2'b00,
    ST_NOLOCK  = 2'b01,
    ST_TIMEOUT = 2'b10
  } cfg_status_e;

  // Port register targeted by configuration step i.
  function automatic logic [DRP_AW-1:0] cfg_addr(input int unsigned i);
    case (i)
      0:       cfg_addr = 7'h08;
      1:       cfg_addr = 7'h09;
      2:       cfg_addr = 7'h14;
      3:       cfg_addr = 7'h15;
      4:       cfg_addr = 7'h16;
      5:       cfg_addr = 7'h18;
      6:       cfg_addr = 7'h19;
      7:       cfg_addr = 7'h1A;
      8:       cfg_addr = 7'h28;
      9:       cfg_addr = 7'h4E;
      default: cfg_addr = 7'h4F;
    endcase
  endfunction

  // Cycles in a 100 us window at the given clock rate, at least one.
  function automatic int settle_cycles(input int hz);
    settle_cycles = (hz / 10000 < 1) ? 1 : hz / 10000;
  endfunction
endpackage

// File: rtl/clkcfg_drp_xact.sv
module clkcfg_drp_xact
  import clkcfg_pkg::*;
#(
  parameter int TIMEOUT = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic              we,
  input  logic [DRP_AW-1:0] addr,
  input  logic [DRP_DW-1:0] wdata,
  input  logic              drp_rdy,
  output logic              drp_en,
  output logic              drp_we,
  output logic [DRP_AW-1:0] drp_addr,
  output logic [DRP_DW-1:0] drp_di,
  output logic              idle,
  output logic              xact_done,
  output logic              xact_timeout
);
  localparam int TW = $clog2(TIMEOUT + 1);

  typedef enum logic [1:0] {X_IDLE, X_STRB, X_WAIT} xst_e;

  xst_e              st;
  logic [TW-1:0]     wcnt;
  logic              we_q;
  logic [DRP_AW-1:0] addr_q;
  logic [DRP_DW-1:0] di_q;
  logic              wait_last;

  assign wait_last    = (wcnt == TW'(TIMEOUT - 1));
  assign drp_en       = (st == X_STRB);
  assign drp_we       = drp_en & we_q;
  assign drp_addr     = addr_q;
  assign drp_di       = di_q;
  assign idle         = (st == X_IDLE);
  assign xact_done    = (st == X_WAIT) && drp_rdy;
  assign xact_timeout = (st == X_WAIT) && !drp_rdy && wait_last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= X_IDLE;
      wcnt   <= '0;
      we_q   <= 1'b0;
      addr_q <= '0;
      di_q   <= '0;
    end else begin
      case (st)
        X_IDLE: if (go) begin
          addr_q <= addr;
          di_q   <= wdata;
          we_q   <= we;
          st     <= X_STRB;
        end
        X_STRB: begin
          wcnt <= '0;
          st   <= X_WAIT;
        end
        X_WAIT: begin
          if (drp_rdy || wait_last) st <= X_IDLE;
          else                      wcnt <= wcnt + 1'b1;
        end
        default: st <= X_IDLE;
      endcase
    end
  end

  // R3
  strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drp_en |=> !drp_en);

  // R3
  go_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    go |-> idle);
endmodule

// File: rtl/clkcfg_settle_timer.sv
module clkcfg_settle_timer #(
  parameter int CYCLES = 25000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  output logic expire
);
  localparam int CW = $clog2(CYCLES + 1);

  logic          running;
  logic [CW-1:0] cnt;

  assign expire = running && (cnt == CW'(CYCLES - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      running <= 1'b0;
      cnt     <= '0;
    end else if (arm) begin
      running <= 1'b1;
      cnt     <= '0;
    end else if (expire) begin
      running <= 1'b0;
    end else if (running) begin
      cnt <= cnt + 1'b1;
    end
  end

  // R4
  arm_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arm |-> !running);
endmodule

// File: rtl/clk_reprog_seq.sv
module clk_reprog_seq
  import clkcfg_pkg::*;
#(
  parameter int CLK_HZ      = 250_000_000,
  parameter int RDY_TIMEOUT = 64
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        start,
  input  logic [NUM_WORDS*DRP_DW-1:0] cfg_words,
  input  logic                        host_req,
  input  logic                        host_we,
  input  logic [DRP_AW-1:0]           host_addr,
  input  logic [DRP_DW-1:0]           host_wdata,
  output logic                        host_ack,
  output logic [DRP_DW-1:0]           host_rdata,
  input  logic                        host_rst,
  output logic                        drp_en,
  output logic                        drp_we,
  output logic [DRP_AW-1:0]           drp_addr,
  output logic [DRP_DW-1:0]           drp_di,
  input  logic [DRP_DW-1:0]           drp_do,
  input  logic                        drp_rdy,
  output logic                        syn_rst,
  input  logic                        syn_locked,
  output logic                        busy,
  output logic                        done,
  output logic [1:0]                  status
);
  localparam int SETTLE_CYC = settle_cycles(CLK_HZ);
  localparam int IDX_W      = $clog2(NUM_WORDS);

  typedef enum logic [2:0] {SQ_IDLE, SQ_ISSUE, SQ_WAIT, SQ_SETTLE, SQ_HOST} sq_e;

  sq_e               st;
  logic [DRP_DW-1:0] words_q [NUM_WORDS];
  logic [IDX_W-1:0]  idx_q;
  logic              rst_q, done_q, ack_q;
  logic [DRP_DW-1:0] rdata_q;
  cfg_status_e       status_q;

  // Named internal events
  logic              start_take, host_take, last_word, settle_arm, settle_expire;
  logic              xact_go, xact_we, xact_done, xact_timeout, xact_idle;
  logic [DRP_AW-1:0] xact_addr;
  logic [DRP_DW-1:0] xact_data;

  assign start_take = (st == SQ_IDLE) && start;
  assign host_take  = (st == SQ_IDLE) && !start && host_req;
  assign last_word  = (idx_q == IDX_W'(NUM_WORDS - 1));
  assign settle_arm = (st == SQ_WAIT) && xact_done && last_word;

  assign xact_go   = (st == SQ_ISSUE) || host_take;
  assign xact_we   = (st == SQ_ISSUE) ? 1'b1 : host_we;
  assign xact_addr = (st == SQ_ISSUE) ? cfg_addr(int'(idx_q)) : host_addr;
  assign xact_data = (st == SQ_ISSUE) ? words_q[idx_q] : host_wdata;

  clkcfg_drp_xact #(.TIMEOUT(RDY_TIMEOUT)) u_xact (
    .clk(clk), .rst_n(rst_n), .go(xact_go), .we(xact_we), .addr(xact_addr),
    .wdata(xact_data), .drp_rdy(drp_rdy), .drp_en(drp_en), .drp_we(drp_we),
    .drp_addr(drp_addr), .drp_di(drp_di), .idle(xact_idle),
    .xact_done(xact_done), .xact_timeout(xact_timeout)
  );

  clkcfg_settle_timer #(.CYCLES(SETTLE_CYC)) u_settle (
    .clk(clk), .rst_n(rst_n), .arm(settle_arm), .expire(settle_expire)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= SQ_IDLE;
      idx_q    <= '0;
      rst_q    <= 1'b0;
      done_q   <= 1'b0;
      ack_q    <= 1'b0;
      rdata_q  <= '0;
      status_q <= ST_OK;
      for (int i = 0; i < NUM_WORDS; i++) words_q[i] <= '0;
    end else begin
      done_q <= 1'b0;
      ack_q  <= 1'b0;
      case (st)
        SQ_IDLE: begin
          if (start_take) begin
            for (int i = 0; i < NUM_WORDS; i++)
              words_q[i] <= cfg_words[i*DRP_DW +: DRP_DW];
            idx_q    <= '0;
            rst_q    <= 1'b1;
            status_q <= ST_OK;
            st       <= SQ_ISSUE;
          end else if (host_take) begin
            st <= SQ_HOST;
          end
        end
        SQ_ISSUE: st <= SQ_WAIT;
        SQ_WAIT: begin
          if (xact_done) begin
            if (last_word) begin
              rst_q <= 1'b0;
              st    <= SQ_SETTLE;
            end else begin
              idx_q <= idx_q + 1'b1;
              st    <= SQ_ISSUE;
            end
          end else if (xact_timeout) begin
            rst_q    <= 1'b0;
            status_q <= ST_TIMEOUT;
            done_q   <= 1'b1;
            st       <= SQ_IDLE;
          end
        end
        SQ_SETTLE: if (settle_expire) begin
          status_q <= syn_locked ? ST_OK : ST_NOLOCK;
          done_q   <= 1'b1;
          st       <= SQ_IDLE;
        end
        SQ_HOST: begin
          if (xact_done) begin
            rdata_q <= drp_do;
            ack_q   <= 1'b1;
            st      <= SQ_IDLE;
          end else if (xact_timeout) begin
            ack_q <= 1'b1;
            st    <= SQ_IDLE;
          end
        end
        default: st <= SQ_IDLE;
      endcase
    end
  end

  assign syn_rst    = (st == SQ_IDLE || st == SQ_HOST) ? host_rst : rst_q;
  assign busy       = (st != SQ_IDLE);
  assign done       = done_q;
  assign status     = status_q;
  assign host_ack   = ack_q;
  assign host_rdata = rdata_q;

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  // R8
  status_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !start_take |=> ($stable(status_q) || done_q));

  // R2
  rst_during_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == SQ_WAIT && drp_en) |-> syn_rst);

  // R5
  timeout_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == SQ_WAIT && xact_timeout) |=> (status_q == ST_TIMEOUT && done_q && !busy));

  // R4
  settle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    settle_expire |-> (st == SQ_SETTLE && !syn_rst));
endmodule

// File: tb/clk_reprog_seq_tb.sv
module clk_reprog_seq_tb;
  localparam int HZ = 1_000_000;
  localparam int TO = 16;
  localparam int NW = 11;
  localparam int SETTLE = HZ / 10000;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [NW*16-1:0] cfg_words = '0;
  logic          host_req = 1'b0, host_we = 1'b0;
  logic [6:0]    host_addr = '0;
  logic [15:0]   host_wdata = '0;
  logic          host_ack;
  logic [15:0]   host_rdata;
  logic          host_rst = 1'b0;
  logic          drp_en, drp_we;
  logic [6:0]    drp_addr;
  logic [15:0]   drp_di;
  logic [15:0]   drp_do = '0;
  logic          drp_rdy = 1'b0;
  logic          syn_rst;
  logic          syn_locked = 1'b0;
  logic          busy, done;
  logic [1:0]    status;

  clk_reprog_seq #(.CLK_HZ(HZ), .RDY_TIMEOUT(TO)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .cfg_words(cfg_words),
    .host_req(host_req), .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_ack(host_ack), .host_rdata(host_rdata),
    .host_rst(host_rst), .drp_en(drp_en), .drp_we(drp_we), .drp_addr(drp_addr),
    .drp_di(drp_di), .drp_do(drp_do), .drp_rdy(drp_rdy), .syn_rst(syn_rst),
    .syn_locked(syn_locked), .busy(busy), .done(done), .status(status)
  );

  int checks = 0, errs = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Behavioural model of the port and of the expected script
  int          exp_addr[$] = '{8, 9, 20, 21, 22, 24, 25, 26, 40, 78, 79};
  logic [15:0] exp_words[NW];
  logic [15:0] mem[128];
  int  lat = 1;
  bit  stall = 0;
  bit  seq_mode = 0;
  int  pend = 0;
  logic [6:0] paddr = '0;
  bit  outstanding = 0, prev_en = 0, prev_done = 0, last_we = 0;
  int  wr_idx = 0, settle_cnt = 0, done_cnt = 0, ack_cnt = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (drp_en && prev_en) chk(0, "R3", "strobe wider than one cycle", 1, 0);
      if (done && prev_done) chk(0, "R8", "done wider than one cycle", 1, 0);
      prev_en = drp_en;
      prev_done = done;
      if (done) done_cnt++;
      if (host_ack) ack_cnt++;
      if (seq_mode && busy && !syn_rst) settle_cnt++;
      drp_rdy = 1'b0;
      if (pend > 0) begin
        pend--;
        if (pend == 0) begin
          drp_rdy = 1'b1;
          drp_do = mem[paddr];
          outstanding = 0;
        end
      end
      if (drp_en) begin
        if (outstanding) chk(0, "R3", "strobe before ack", 1, 0);
        last_we = drp_we;
        if (seq_mode) begin
          if (wr_idx < NW) begin
            chk(int'(drp_addr) == exp_addr[wr_idx], "R1", "write address",
                drp_addr, exp_addr[wr_idx]);
            chk(drp_di == exp_words[wr_idx], "R1", "write data", drp_di, exp_words[wr_idx]);
          end else chk(0, "R1", "extra write", wr_idx, NW);
          chk(syn_rst == 1'b1, "R2", "reset during write", syn_rst, 1);
          chk(drp_we == 1'b1, "R3", "we with write strobe", drp_we, 1);
          wr_idx++;
        end
        if (!stall) begin
          pend = lat;
          paddr = drp_addr;
          outstanding = 1;
          if (drp_we) mem[drp_addr] = drp_di;
        end
      end
    end
  end

  task automatic wait_done(output bit seen);
    seen = 0;
    for (int i = 0; i < 5000 && !seen; i++) begin
      @(posedge clk); #1;
      if (done) seen = 1;
    end
  endtask

  task automatic load_words(input logic [15:0] base);
    for (int i = 0; i < NW; i++) begin
      cfg_words[i*16 +: 16] = base + 16'(i * 16'h0111);
      exp_words[i] = base + 16'(i * 16'h0111);
    end
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic host_op(input bit w, input logic [6:0] a, input logic [15:0] d,
                         output bit seen);
    @(negedge clk);
    host_req = 1'b1; host_we = w; host_addr = a; host_wdata = d;
    @(negedge clk); host_req = 1'b0;
    seen = 0;
    for (int i = 0; i < 200 && !seen; i++) begin
      @(posedge clk); #1;
      if (host_ack) seen = 1;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errs++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errs);
    $finish;
  end

  initial begin
    bit seen;
    int d0, a0;
    for (int i = 0; i < 128; i++) mem[i] = '0;
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;
    // R11 reset state
    chk(busy == 0 && done == 0 && host_ack == 0, "R11", "control outputs", {busy, done, host_ack}, 0);
    chk(drp_en == 0 && status == 2'b00, "R11", "strobe and status", {drp_en, status}, 0);

    // Run 1: fast ready, locked, late input changes and a second start
    lat = 1; syn_locked = 1'b1; load_words(16'h1000);
    seq_mode = 1; wr_idx = 0; settle_cnt = 0; d0 = done_cnt; a0 = ack_cnt;
    pulse_start();
    @(posedge clk); #1;
    chk(syn_rst == 1'b1 && busy == 1'b1, "R2", "reset asserted at run start", syn_rst, 1);
    repeat (3) @(negedge clk);
    for (int i = 0; i < NW; i++) cfg_words[i*16 +: 16] = 16'hDEAD; // R6
    start = 1'b1; host_req = 1'b1; host_we = 1'b0; host_addr = 7'h08; // R7
    @(negedge clk); start = 1'b0; host_req = 1'b0;
    wait_done(seen);
    seq_mode = 0;
    chk(seen, "R4", "done seen", seen, 1);
    chk(status == 2'b00, "R4", "locked status", status, 0);
    chk(wr_idx == NW, "R1", "write count", wr_idx, NW);
    chk(settle_cnt == SETTLE, "R4", "settle cycles", settle_cnt, SETTLE);
    chk(syn_rst == 1'b0, "R2", "reset released", syn_rst, 0);
    repeat (20) @(posedge clk); #1;
    chk(done_cnt == d0 + 1, "R7", "single run despite second start", done_cnt - d0, 1);
    chk(ack_cnt == a0, "R7", "host request during busy ignored", ack_cnt - a0, 0);
    chk(busy == 1'b0, "R7", "idle after run", busy, 0);
    chk(status == 2'b00, "R8", "status holds", status, 0);
    chk(mem[8'h08] == 16'h1000, "R6", "word0 unaffected by late change", mem[8'h08], 16'h1000);

    // R10 host reset when idle
    @(negedge clk); host_rst = 1'b1; #1;
    chk(syn_rst == 1'b1, "R10", "host reset when idle", syn_rst, 1);
    @(negedge clk); host_rst = 1'b0; #1;
    chk(syn_rst == 1'b0, "R10", "host reset release when idle", syn_rst, 0);

    // Run 2: slow ready, no lock, host reset ignored during run
    lat = 3; syn_locked = 1'b0; load_words(16'h2200);
    seq_mode = 1; wr_idx = 0; settle_cnt = 0;
    pulse_start();
    host_rst = 1'b1;
    for (int i = 0; i < 5000 && !(busy && !syn_rst); i++) @(negedge clk);
    chk(busy && !syn_rst, "R10", "host reset ignored in settle", syn_rst, 0);
    wait_done(seen);
    seq_mode = 0;
    chk(status == 2'b01, "R4", "no-lock status", status, 1);
    chk(wr_idx == NW, "R1", "write count slow port", wr_idx, NW);
    chk(settle_cnt == SETTLE, "R4", "settle cycles slow port", settle_cnt, SETTLE);
    chk(syn_rst == 1'b1, "R10", "follows host reset after run", syn_rst, 1);
    @(negedge clk); host_rst = 1'b0;

    // R9 host write then reads
    host_op(1'b1, 7'h30, 16'h5A5A, seen);
    chk(seen, "R9", "host write ack", seen, 1);
    chk(last_we == 1'b1, "R3", "we on host write", last_we, 1);
    host_op(1'b0, 7'h30, 16'h0000, seen);
    chk(seen && host_rdata == 16'h5A5A, "R9", "host read back", host_rdata, 16'h5A5A);
    chk(last_we == 1'b0, "R3", "no we on read", last_we, 0);
    host_op(1'b0, 7'h4F, 16'h0000, seen);
    chk(host_rdata == exp_words[NW-1], "R1", "last word at 0x4F", host_rdata, exp_words[NW-1]);

    // Run 3: stalled port gives timeout
    stall = 1; syn_locked = 1'b1; load_words(16'h3300);
    seq_mode = 1; wr_idx = 0;
    pulse_start();
    @(posedge clk); #1;
    chk(status == 2'b00, "R8", "status cleared by start", status, 0);
    wait_done(seen);
    seq_mode = 0;
    chk(seen && status == 2'b10, "R5", "timeout status", status, 2);
    chk(wr_idx == 1, "R5", "abort after first write", wr_idx, 1);
    chk(syn_rst == 1'b0 && busy == 1'b0, "R5", "reset released on abort", {syn_rst, busy}, 0);
    stall = 0;
    repeat (5) @(posedge clk); #1;
    chk(status == 2'b10, "R8", "timeout status holds", status, 2);

    $display("Simulation finished: %0d checks, %0d errors", checks, errs);
    $finish;
  end
endmodule